// File: doc/BRIEF.md
# Ranked-Slot Interrupt Controller

This block collects up to 32 level-sensitive interrupt sources, split into four groups of eight, and reduces them to two active-high request lines for a processor: a normal line and an urgent line. Each group has a ranking word. Software writes a 3-bit group-local source code into each of eight ranked positions, and the block serves the highest-ranked position whose source is both pending and enabled. Within each group, the top two positions can each be sent to the urgent line. Each group can also be switched from group-ordered to rank-interleaved arbitration. Separately, a single source can be named as an override that beats every other source. The override is delivered on whichever line software selects.

Software reaches the block through a plain 32-bit word-addressed read/write port. A read of either vector word returns the number of the winning source for that line, or zero when that line is idle. Source levels are sampled into a register on each clock. Both vectors are derived combinationally from the registered levels and the configuration, so any change of a source level is visible one clock later.

Top module: `gpic_top`

## Requirements
- R1: The enable word sits at word address 0. Its bit i enables source i+1 when set and masks it when clear. A write lands on the next clock and reads back unchanged. A masked source never appears on either vector.
- R2: Reset is synchronous and active high. It clears every register, so both vectors read zero and both request lines are low even when all sources are asserted.
- R3: The normal vector reads at word 3 and the urgent vector at word 4. Each carries the source number in bits 31:26, with all other bits zero, and zero means idle. irq_low and irq_high are high exactly when their vector is nonzero. A source-level change shows on the vector and the line one clock after it is sampled, and not before.
- R4: The ranking word for group g sits at word 8+g. Its positions 1 to 8 hold codes at bit offsets 29, 26, 23, 12, 9, 6, 3 and 0, and position 1 ranks highest. The group candidate comes from the highest-ranked position whose code names an active source. Positions whose code names no active source are skipped.
- R5: Code c in group g names source g*8+c+1 and mask bit g*8+c. A source whose code is in no position of its group never wins.
- R6: When every group is group-ordered, a candidate from a lower-numbered group beats any candidate from a higher-numbered group.
- R7: The control word sits at word 1. Its bit 16+g set puts group g in rank-interleaved mode. Across groups, the winner has the smallest key, where the key is the position index (0 to 7) for an interleaved group and 0 for a group-ordered group. Ties go to the lower group number.
- R8: The routing word sits at word 2. For group g, the field for position 1 is bits 4g+3:4g+2 and the field for position 2 is bits 4g+1:4g. A field value of 01 sends that position to the urgent line, and any other value leaves it on the normal line. Positions 3 to 8 always go to the normal line.
- R9: The normal line arbitrates only among positions not sent to the urgent line. When a group's top active position goes urgent, the group's next normal-line position still competes on the normal line.
- R10: Control bits 5:0 name an override source, where 0 means none. When that source is active, it is the vector of the line chosen by control bit 8 (1 selects urgent, 0 selects normal). It then takes no part in ordinary arbitration on either line.
- R11: Sources are levels. A vectored source disappears one clock after it deasserts or is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when set, read otherwise |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_level | input | 32 | Source levels, bit i is source i+1 |
| irq_low | output | 1 | Normal request line |
| irq_high | output | 1 | Urgent request line |

## Verification
Two functions can act in the same clock: the override and the urgent routing both claim the urgent line, and a mask write can land on the same edge as a rising source level. The bench provokes the first case by naming a low-ranked source as override while another source sits on the normal line. It checks that both lines carry distinct, correct vectors in that cycle. For the second case, it drives a new source level and a mask write that disables that source before the same edge, then requires the normal vector to stay zero after that edge.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int CODE_W      = 3;
    localparam int SLOTS       = 8;
    localparam int SRC_PER_GRP = 1 << CODE_W;
    localparam int VEC_W       = 6;
    localparam int ROUTE_W     = 2;
    localparam int HP_W        = 6;

    localparam int A_MASK    = 0;
    localparam int A_CTRL    = 1;
    localparam int A_ROUTE   = 2;
    localparam int A_VLO     = 3;
    localparam int A_VHI     = 4;
    localparam int PRIO_BASE = 8;

    localparam int CTRL_HPSEL_BIT  = 8;
    localparam int CTRL_SPREAD_LSB = 16;
    localparam logic [ROUTE_W-1:0] ROUTE_TO_HIGH = 2'b01;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] rank;
        logic [CODE_W-1:0] code;
    } cand_t;

    // bit offset of ranked position k (0 = highest) inside a ranking word
    function automatic int slot_pos(int k);
        return (k < 3) ? (29 - 3 * k) : (12 - 3 * (k - 3));
    endfunction
endpackage

// File: rtl/gpic_regs.sv
module gpic_regs
    import gpic_pkg::*;
#(
    parameter int NG   = 4,
    parameter int NSRC = NG * SRC_PER_GRP
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NSRC-1:0]            src_level,
    input  logic [VEC_W-1:0]           vec_lo,
    input  logic [VEC_W-1:0]           vec_hi,
    output logic [NSRC-1:0]            mask_q,
    output logic [NSRC-1:0]            pend_q,
    output logic [HP_W-1:0]            hp_id_q,
    output logic                       hp_sel_q,
    output logic [NG-1:0]              spread_q,
    output logic [NG*2*ROUTE_W-1:0]    route_q,
    output logic [SLOTS*CODE_W-1:0]    codes_q [NG]
);
    localparam int RT_W = NG * 2 * ROUTE_W;

    logic wr_en;
    assign wr_en = bus_sel && bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            pend_q   <= '0;
            hp_id_q  <= '0;
            hp_sel_q <= 1'b0;
            spread_q <= '0;
            route_q  <= '0;
        end else begin
            pend_q <= src_level;
            if (wr_en && bus_addr == ADDR_W'(A_MASK))
                mask_q <= bus_wdata[NSRC-1:0];
            if (wr_en && bus_addr == ADDR_W'(A_CTRL)) begin
                hp_id_q  <= bus_wdata[HP_W-1:0];
                hp_sel_q <= bus_wdata[CTRL_HPSEL_BIT];
                spread_q <= bus_wdata[CTRL_SPREAD_LSB +: NG];
            end
            if (wr_en && bus_addr == ADDR_W'(A_ROUTE))
                route_q <= bus_wdata[RT_W-1:0];
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst) begin
                codes_q[g] <= '0;
            end else if (wr_en && bus_addr == ADDR_W'(PRIO_BASE + g)) begin
                for (int k = 0; k < SLOTS; k++)
                    codes_q[g][k*CODE_W +: CODE_W] <= bus_wdata[slot_pos(k) +: CODE_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            A_MASK:  bus_rdata[NSRC-1:0] = mask_q;
            A_CTRL: begin
                bus_rdata[HP_W-1:0]               = hp_id_q;
                bus_rdata[CTRL_HPSEL_BIT]         = hp_sel_q;
                bus_rdata[CTRL_SPREAD_LSB +: NG]  = spread_q;
            end
            A_ROUTE: bus_rdata[RT_W-1:0] = route_q;
            A_VLO:   bus_rdata[DATA_W-1 -: VEC_W] = vec_lo;
            A_VHI:   bus_rdata[DATA_W-1 -: VEC_W] = vec_hi;
            default: begin
                for (int g = 0; g < NG; g++)
                    if (int'(bus_addr) == PRIO_BASE + g)
                        for (int k = 0; k < SLOTS; k++)
                            bus_rdata[slot_pos(k) +: CODE_W] = codes_q[g][k*CODE_W +: CODE_W];
            end
        endcase
    end
endmodule

// File: rtl/gpic_group_scan.sv
module gpic_group_scan
    import gpic_pkg::*;
(
    input  logic [SLOTS*CODE_W-1:0] codes,
    input  logic [SRC_PER_GRP-1:0]  act,
    input  logic [2*ROUTE_W-1:0]    route,
    output cand_t                   cand_lo,
    output cand_t                   cand_hi
);
    logic [CODE_W-1:0] code_k;
    logic              hi_ok;

    always_comb begin
        cand_lo = '0;
        cand_hi = '0;
        code_k  = '0;
        hi_ok   = 1'b0;
        // walk from lowest rank upward so the highest active rank is kept last
        for (int k = SLOTS - 1; k >= 0; k--) begin
            code_k = codes[k*CODE_W +: CODE_W];
            hi_ok  = (k == 0 && route[2*ROUTE_W-1 -: ROUTE_W] == ROUTE_TO_HIGH) ||
                     (k == 1 && route[ROUTE_W-1:0] == ROUTE_TO_HIGH);
            if (act[code_k]) begin
                if (hi_ok)
                    cand_hi = '{vld: 1'b1, rank: CODE_W'(k), code: code_k};
                else
                    cand_lo = '{vld: 1'b1, rank: CODE_W'(k), code: code_k};
            end
        end
    end
endmodule

// File: rtl/gpic_merge.sv
module gpic_merge
    import gpic_pkg::*;
#(
    parameter int NG = 4
) (
    input  cand_t            cand [NG],
    input  logic [NG-1:0]    spread,
    output logic [VEC_W-1:0] vec
);
    logic              found;
    logic [CODE_W-1:0] best_key;
    logic [CODE_W-1:0] key;

    always_comb begin
        found    = 1'b0;
        best_key = '0;
        key      = '0;
        vec      = '0;
        for (int g = 0; g < NG; g++) begin
            key = spread[g] ? cand[g].rank : '0;
            if (cand[g].vld && (!found || key < best_key)) begin
                found    = 1'b1;
                best_key = key;
                vec      = VEC_W'(g * SRC_PER_GRP + int'(cand[g].code) + 1);
            end
        end
    end
endmodule

// File: rtl/gpic_top.sv
module gpic_top
    import gpic_pkg::*;
#(
    parameter  int NUM_GROUPS = 4,
    localparam int NSRC       = NUM_GROUPS * SRC_PER_GRP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_level,
    output logic              irq_low,
    output logic              irq_high
);
    localparam int RG_W = 2 * ROUTE_W;

    logic [NSRC-1:0]            mask_q, pend_q, active, hp_onehot, arb;
    logic [HP_W-1:0]            hp_id_q;
    logic                       hp_sel_q, hp_hit;
    logic [NUM_GROUPS-1:0]      spread_q;
    logic [NUM_GROUPS*RG_W-1:0] route_q;
    logic [SLOTS*CODE_W-1:0]    codes_q [NUM_GROUPS];
    cand_t                      cand_lo [NUM_GROUPS];
    cand_t                      cand_hi [NUM_GROUPS];
    logic [VEC_W-1:0]           arb_lo, arb_hi, vec_lo, vec_hi;

    gpic_regs #(.NG(NUM_GROUPS), .NSRC(NSRC)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_level(src_level), .vec_lo(vec_lo), .vec_hi(vec_hi),
        .mask_q(mask_q), .pend_q(pend_q),
        .hp_id_q(hp_id_q), .hp_sel_q(hp_sel_q), .spread_q(spread_q),
        .route_q(route_q), .codes_q(codes_q)
    );

    assign active = pend_q & mask_q;

    always_comb begin
        hp_onehot = '0;
        for (int i = 0; i < NSRC; i++)
            if (int'(hp_id_q) == i + 1)
                hp_onehot[i] = active[i];
    end
    assign hp_hit = |hp_onehot;
    assign arb    = active & ~hp_onehot;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_scan
        gpic_group_scan u_scan (
            .codes(codes_q[g]),
            .act(arb[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .route(route_q[g*RG_W +: RG_W]),
            .cand_lo(cand_lo[g]),
            .cand_hi(cand_hi[g])
        );
    end

    gpic_merge #(.NG(NUM_GROUPS)) u_merge_lo (.cand(cand_lo), .spread(spread_q), .vec(arb_lo));
    gpic_merge #(.NG(NUM_GROUPS)) u_merge_hi (.cand(cand_hi), .spread(spread_q), .vec(arb_hi));

    assign vec_lo   = (hp_hit && !hp_sel_q) ? hp_id_q : arb_lo;
    assign vec_hi   = (hp_hit &&  hp_sel_q) ? hp_id_q : arb_hi;
    assign irq_low  = |vec_lo;
    assign irq_high = |vec_hi;
endmodule

// File: rtl/gpic_chk.sv
module gpic_chk
    import gpic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   pend_q,
    input logic [VEC_W-1:0]  vec_lo,
    input logic [VEC_W-1:0]  vec_hi,
    input logic              irq_low,
    input logic              irq_high
);
    function automatic logic bit_of(logic [NSRC-1:0] v, logic [VEC_W-1:0] id);
        if (id == '0 || int'(id) > NSRC) return 1'b0;
        return v[int'(id) - 1];
    endfunction

    a_r1_masked_never_vectored: assert property (@(posedge clk) disable iff (rst)
        (vec_lo != '0 || vec_hi != '0) |->
            ((vec_lo == '0 || bit_of(mask_q, vec_lo)) && (vec_hi == '0 || bit_of(mask_q, vec_hi))));

    a_r1_mask_write_lands: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(A_MASK)) |=> (mask_q == $past(bus_wdata[NSRC-1:0])));

    a_r2_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_low && !irq_high));

    a_r11_vector_is_pending: assert property (@(posedge clk) disable iff (rst)
        (vec_lo != '0 || vec_hi != '0) |->
            ((vec_lo == '0 || bit_of(pend_q, vec_lo)) && (vec_hi == '0 || bit_of(pend_q, vec_hi))));

    a_r9_lines_distinct: assert property (@(posedge clk) disable iff (rst)
        (vec_lo != '0) |-> (vec_lo != vec_hi));
endmodule

bind gpic_top gpic_chk #(.NSRC(NSRC)) u_chk (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mask_q(mask_q), .pend_q(pend_q),
    .vec_lo(vec_lo), .vec_hi(vec_hi),
    .irq_low(irq_low), .irq_high(irq_high)
);

// File: tb/gpic_top_tb.sv
`timescale 1ns/1ps
module gpic_top_tb_top;
    localparam real CYC = 20.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_level = '0;
    logic        irq_low, irq_high;

    int total = 0;
    int bad = 0;

    always #(CYC/2) clk = ~clk;

    gpic_top dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_level(src_level), .irq_low(irq_low), .irq_high(irq_high)
    );

    // mask, source levels, expected normal vector
    localparam logic [69:0] TBL [14] = '{
        {32'hFFFF_FFFF, 32'h0000_0000, 6'd0},
        {32'hFFFF_FFFF, 32'h0000_0001, 6'd1},
        {32'hFFFF_FFFF, 32'h0000_0005, 6'd3},
        {32'hFFFF_FFFF, 32'h0000_0002, 6'd2},
        {32'hFFFF_FFFF, 32'h0000_2100, 6'd14},
        {32'hFFFF_FFFF, 32'h0000_0102, 6'd2},
        {32'hFFFF_FFFF, 32'h8000_0000, 6'd32},
        {32'hFFFF_FFFF, 32'h0000_0600, 6'd11},
        {32'hFFFF_FFFF, 32'h8001_0000, 6'd17},
        {32'hFFFF_FFFB, 32'h0000_0005, 6'd1},
        {32'h0000_0000, 32'hFFFF_FFFF, 6'd0},
        {32'hFFFF_DFFF, 32'h0000_2100, 6'd9},
        {32'hFFFF_FFFF, 32'h0000_0008, 6'd0},
        {32'hFFFF_FFFF, 32'h0000_0088, 6'd8}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 4'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic apply(input logic [31:0] s);
        @(negedge clk);
        src_level = s;
        @(posedge clk); #1;
    endtask

    task automatic expect_vecs(input logic [5:0] lo, input logic [5:0] hi, input string req);
        logic [31:0] v;
        rd(3, v);
        chk(v == {lo, 26'b0} && irq_low == (lo != 0), req, v, {lo, 26'b0});
        rd(4, v);
        chk(v == {hi, 26'b0} && irq_high == (hi != 0), req, v, {hi, 26'b0});
    endtask

    function automatic logic [31:0] mk_prio(input int c0, input int c1, input int c2, input int c3,
                                            input int c4, input int c5, input int c6, input int c7);
        logic [31:0] w = '0;
        w[31:29] = 3'(c0); w[28:26] = 3'(c1); w[25:23] = 3'(c2);
        w[14:12] = 3'(c3); w[11:9]  = 3'(c4); w[8:6]   = 3'(c5);
        w[5:3]   = 3'(c6); w[2:0]   = 3'(c7);
        return w;
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CYC * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] v;
        // R2: reset with every source asserted
        src_level = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        rd(0, v); chk(v == 0, "R2 mask reset", v, 0);
        rd(1, v); chk(v == 0, "R2 ctrl reset", v, 0);
        rd(8, v); chk(v == 0, "R2 rank reset", v, 0);
        expect_vecs(0, 0, "R2 idle after reset");

        // R4 ranking words, read back in R4 layout
        wr(8,  mk_prio(2, 0, 1, 7, 7, 7, 7, 7));
        wr(9,  mk_prio(5, 4, 3, 2, 1, 0, 6, 7));
        wr(10, mk_prio(0, 1, 2, 3, 4, 5, 6, 7));
        wr(11, mk_prio(0, 1, 2, 3, 4, 5, 6, 7));
        rd(9, v); chk(v == mk_prio(5, 4, 3, 2, 1, 0, 6, 7), "R4 rank readback", v, mk_prio(5, 4, 3, 2, 1, 0, 6, 7));

        // R1 R4 R5 R6: table walk
        for (int i = 0; i < 14; i++) begin
            wr(0, TBL[i][69:38]);
            apply(TBL[i][37:6]);
            expect_vecs(TBL[i][5:0], 0, "R4/R5/R6/R1 table");
        end
        rd(0, v); chk(v == 32'hFFFF_FFFF, "R1 mask readback", v, 32'hFFFF_FFFF);

        // R3: latency and field position
        apply(0);
        @(negedge clk); src_level = 32'h1; #1;
        chk(irq_low == 1'b0, "R3 not before edge", {31'b0, irq_low}, 0);
        @(posedge clk); #1;
        rd(3, v); chk(v == 32'h0400_0000 && irq_low, "R3 vector bits 31:26", v, 32'h0400_0000);

        // R11: deassert drops it
        apply(0);
        expect_vecs(0, 0, "R11 level deassert");

        // R7 interleaved ordering
        apply(32'h0000_2002);
        expect_vecs(2, 0, "R6 group order");
        wr(1, 32'h0001_0000);
        expect_vecs(14, 0, "R7 g0 interleaved");
        wr(1, 32'h0003_0000);
        expect_vecs(14, 0, "R7 both interleaved");
        wr(1, 32'h0002_0000);
        expect_vecs(2, 0, "R7 tie to lower group");
        wr(1, 0);

        // R8 R9 routing
        apply(32'h0000_3000);
        wr(2, 32'h40);
        expect_vecs(13, 14, "R8/R9 slot1 urgent");
        wr(2, 32'h50);
        expect_vecs(0, 14, "R9 both slots urgent");
        apply(32'h0000_3001);
        expect_vecs(1, 14, "R9 other group normal");
        wr(2, 32'h80);
        apply(32'h0000_3000);
        expect_vecs(14, 0, "R8 field value 10 stays normal");
        wr(2, 32'h4);
        apply(32'h0000_0005);
        expect_vecs(1, 3, "R8 group0 slot1 urgent");
        wr(2, 0);

        // R10 override and both lines in one cycle
        apply(32'h8000_0001);
        wr(1, 32);
        expect_vecs(32, 0, "R10 override normal");
        wr(1, 32 | (1 << 8));
        expect_vecs(1, 32, "R10 override urgent");
        wr(0, 32'h7FFF_FFFF);
        expect_vecs(1, 0, "R10 masked override");
        wr(0, 32'hFFFF_FFFF);
        wr(1, 0);

        // R1 mask write on the same edge as a rising source
        apply(0);
        @(negedge clk);
        src_level = 32'h1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'hFFFF_FFFE;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        expect_vecs(0, 0, "R1 mask write with rising source");
        wr(0, 32'hFFFF_FFFF);
        expect_vecs(1, 0, "R1 unmask shows source");

        summary();
    end
endmodule